// File: doc/BRIEF.md
# Cartridge Bank and Protection-Transform Unit

This block is the register logic of a game-cartridge bank controller on an 8-bit CPU bus. A bank register drives two upper program-ROM address lines and a nametable mirroring select. The mirroring select steers one of two video-side address lines onto the nametable RAM address output. An 8-bit index register selects a protection transform. Four result registers each store a written byte after it passes through that transform, and the CPU reads them back. The AND and XOR masks of the transform are built from fixed sum-of-products logic on the index, so no table is stored. A spare two-input OR gate is also included.

The design runs from a fast system clock and samples the CPU phase signal M2 as data. The bus sequencer has three states. In `ST_IDLE`, M2 is low. `ST_ACTIVE` is entered from `ST_IDLE` or `ST_COMMIT` when M2 is seen high, and it latches the bus on every cycle while M2 stays high. `ST_COMMIT` is entered from `ST_ACTIVE` when M2 is seen low, and it applies the latched write for exactly one cycle. From `ST_COMMIT` the sequencer returns to `ST_IDLE`, or to `ST_ACTIVE` if M2 is already high again. The CPU's A15 is not a pin. The upper register window counts as addressed only while the ROM-select strobe is inactive (high).

Top module: `cart_prot_mapper`

## Requirements
- R1: After reset, bank_a16, bank_a15 and the mirroring select are 0, so nt_a10 follows ppu_a10. The index register and all four result registers read back as 0.
- R2: A write with rom_window_n=1 and cpu_addr_hi (A14..A11)=4'b1001 loads the bank register, whatever the value of cpu_addr_lo. Data bit 0 drives bank_a16, bit 4 drives bank_a15 and bit 5 is the mirroring select. The other data bits have no effect.
- R3: nt_a10 equals ppu_a10 when the mirroring select is 0, and equals ppu_a11 when it is 1.
- R4: A write with rom_window_n=1 and cpu_addr_hi=4'b1010 loads all 8 bits of the index register, whatever the value of cpu_addr_lo.
- R5: A write with rom_window_n=1 and cpu_addr_hi=4'b1011 stores (data & AND-mask(index)) ^ XOR-mask(index) into the result register numbered cpu_addr_lo ({A1,A0}). The other three result registers are left unchanged.
- R6: A read with m2=1, cpu_rw=1, rom_window_n=1 and cpu_addr_hi=4'b1011 drives cpu_doe=1 and drives cpu_dout with result register cpu_addr_lo. In every other case cpu_doe=0.
- R7: In the XOR mask, bits 7, 5, 2 and 1 are 0. The other bits are: bit0=i7&~i3 | ~i7&~i6; bit3=i4&~i3 | ~i6&~i4; bit4=~i6&~i0 | ~i3&i0; bit6=~i6&~i1 | ~i3&i1. Index 0 gives 0x59 and index 9 gives 0x49.
- R8: In the AND mask, bits 7, 5, 2 and 1 are 1. The other bits are: bit0=~i7~i6~i5 | i7~i3~i2 | ~i7 i6 i5 | i7 i3 i2; bit3=~i6~i5~i4 | i6 i5~i4 | i4~i3~i2 | i4 i3 i2; bit4=~i6~i5~i0 | i6 i5~i0 | ~i3~i2 i0 | i3 i2 i0; bit6=~i6~i5~i1 | i6 i5~i1 | ~i3~i2 i1 | i3 i2 i1. Index 0 gives 0xFF.
- R9: A write commits only after M2 falls. The affected register keeps its old value while M2 is still high, and it holds the new value no later than three clock cycles after M2 goes low.
- R10: Writes with cpu_addr_hi in 4'b1100..4'b1111, writes with rom_window_n=0, and cycles with cpu_rw=1 change no register.
- R11: or_y equals or_a | or_b at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_hi | input | 4 | CPU address bits A14..A11 |
| cpu_addr_lo | input | 2 | CPU address bits {A1,A0} |
| cpu_din | input | 8 | CPU write data |
| cpu_dout | output | 8 | CPU read data |
| cpu_doe | output | 1 | Read data output enable |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU bus phase signal |
| rom_window_n | input | 1 | ROM-select strobe; high means A15=0 |
| ppu_a10 | input | 1 | Video address line 10 |
| ppu_a11 | input | 1 | Video address line 11 |
| nt_a10 | output | 1 | Nametable RAM address line 10 |
| bank_a16 | output | 1 | Program ROM address line 16 |
| bank_a15 | output | 1 | Program ROM address line 15 |
| or_a | input | 1 | Spare OR gate input A |
| or_b | input | 1 | Spare OR gate input B |
| or_y | output | 1 | Spare OR gate output |

## Verification
The assertions check, on every cycle:
- each commit strobe comes exactly one cycle after M2 was seen falling;
- the index and bank registers hold their value whenever no strobe is present;
- the fixed mask bits keep their values;
- the read enable is active only during a qualified read phase.

Only the bench scenarios can show the following:
- that every one of the 256 index values gives the expected AND and XOR masks, observed through writes of 0x00 and 0xFF followed by reads;
- that the address lines A1/A0 select the correct result register and are ignored for the other registers;
- that accesses outside the register window leave all state unchanged.

// File: rtl/cart_prot_pkg.sv
package cart_prot_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_RES  = 4;
    localparam int SEL_W    = $clog2(NUM_RES);
    localparam int HI_W     = 4;

    localparam logic [HI_W-1:0] CODE_BANK   = 4'b1001;
    localparam logic [HI_W-1:0] CODE_INDEX  = 4'b1010;
    localparam logic [HI_W-1:0] CODE_RESULT = 4'b1011;

    localparam int BIT_A16 = 0;
    localparam int BIT_A15 = 4;
    localparam int BIT_MIR = 5;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_BANK,
        REG_INDEX,
        REG_RESULT
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_COMMIT
    } bus_state_e;

    function automatic region_e decode_region(input logic win_n, input logic [HI_W-1:0] hi);
        region_e r;
        r = REG_NONE;
        if (win_n) begin
            unique case (hi)
                CODE_BANK:   r = REG_BANK;
                CODE_INDEX:  r = REG_INDEX;
                CODE_RESULT: r = REG_RESULT;
                default:     r = REG_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/cart_prot_mask_gen.sv
module cart_prot_mask_gen
    import cart_prot_pkg::*;
(
    input  logic [DATA_W-1:0] idx,
    output logic [DATA_W-1:0] and_mask,
    output logic [DATA_W-1:0] xor_mask
);
    logic i0, i1, i2, i3, i4, i5, i6, i7;
    logic hi_eq;
    logic lo_eq_hi;
    logic lo_eq_lo;

    always_comb begin
        {i7, i6, i5, i4, i3, i2, i1, i0} = idx;
        hi_eq    = (i6 == i5);
        lo_eq_hi = i3 & i2;
        lo_eq_lo = ~i3 & ~i2;
    end

    always_comb begin
        xor_mask    = '0;
        xor_mask[0] = (i7 & ~i3) | (~i7 & ~i6);
        xor_mask[3] = (i4 & ~i3) | (~i6 & ~i4);
        xor_mask[4] = (~i6 & ~i0) | (~i3 & i0);
        xor_mask[6] = (~i6 & ~i1) | (~i3 & i1);
    end

    always_comb begin
        and_mask    = '1;
        and_mask[0] = (~i7 & ~i6 & ~i5) | (i7 & lo_eq_lo) | (~i7 & i6 & i5) | (i7 & lo_eq_hi);
        and_mask[3] = (hi_eq & ~i4 & (i6 == ~i5 ? 1'b0 : 1'b1) & ((~i6 & ~i5) | (i6 & i5)))
                    | (i4 & lo_eq_lo) | (i4 & lo_eq_hi);
        and_mask[4] = (((~i6 & ~i5) | (i6 & i5)) & ~i0) | (lo_eq_lo & i0) | (lo_eq_hi & i0);
        and_mask[6] = (((~i6 & ~i5) | (i6 & i5)) & ~i1) | (lo_eq_lo & i1) | (lo_eq_hi & i1);
    end

    // R7/R8: fixed mask bits never move
    always_comb begin
        if (!$isunknown(idx)) begin
            assert_fixed_bits_R7: assert (xor_mask[7] == 1'b0 && xor_mask[5] == 1'b0 &&
                                          xor_mask[2] == 1'b0 && xor_mask[1] == 1'b0);
            assert_fixed_bits_R8: assert (and_mask[7] && and_mask[5] && and_mask[2] && and_mask[1]);
        end
    end
endmodule

// File: rtl/cart_prot_bus_seq.sv
module cart_prot_bus_seq
    import cart_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m2,
    input  logic              rw,
    input  logic              win_n,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [SEL_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] din,
    output logic              bank_we,
    output logic              index_we,
    output logic              res_we,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [DATA_W-1:0] wr_data
);
    bus_state_e state_q, state_d;
    region_e    cap_region_q;
    logic       cap_wr_q;
    logic [SEL_W-1:0]  cap_sel_q;
    logic [DATA_W-1:0] cap_data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (m2) state_d = ST_ACTIVE;
            ST_ACTIVE: if (!m2) state_d = ST_COMMIT;
            ST_COMMIT: state_d = m2 ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // latch the most recent bus sample seen while M2 is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_region_q <= REG_NONE;
            cap_wr_q     <= 1'b0;
            cap_sel_q    <= '0;
            cap_data_q   <= '0;
        end else if (m2) begin
            cap_region_q <= decode_region(win_n, addr_hi);
            cap_wr_q     <= ~rw;
            cap_sel_q    <= addr_lo;
            cap_data_q   <= din;
        end
    end

    always_comb begin
        bank_we  = 1'b0;
        index_we = 1'b0;
        res_we   = 1'b0;
        if (state_q == ST_COMMIT && cap_wr_q) begin
            unique case (cap_region_q)
                REG_BANK:   bank_we  = 1'b1;
                REG_INDEX:  index_we = 1'b1;
                REG_RESULT: res_we   = 1'b1;
                default: ;
            endcase
        end
        wr_sel  = cap_sel_q;
        wr_data = cap_data_q;
    end

    // R9: every commit strobe follows an observed falling edge of M2
    assert_commit_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we || index_we || res_we) |-> (!$past(m2) && $past(m2, 2)));

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_we, index_we, res_we}));
endmodule

// File: rtl/cart_prot_regs.sv
module cart_prot_regs
    import cart_prot_pkg::*;
#(
    parameter int N_RES = NUM_RES,
    localparam int SW   = $clog2(N_RES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bank_we,
    input  logic                         index_we,
    input  logic                         res_we,
    input  logic [SW-1:0]                wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [DATA_W-1:0]            and_mask,
    input  logic [DATA_W-1:0]            xor_mask,
    output logic [DATA_W-1:0]            index_q,
    output logic                         a16_q,
    output logic                         a15_q,
    output logic                         mir_q,
    output logic [N_RES-1:0][DATA_W-1:0] res_q
);
    logic [DATA_W-1:0] transformed;

    always_comb transformed = (wr_data & and_mask) ^ xor_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a16_q <= 1'b0;
            a15_q <= 1'b0;
            mir_q <= 1'b0;
        end else if (bank_we) begin
            a16_q <= wr_data[BIT_A16];
            a15_q <= wr_data[BIT_A15];
            mir_q <= wr_data[BIT_MIR];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (index_we) begin
            index_q <= wr_data;
        end
    end

    for (genvar k = 0; k < N_RES; k++) begin : g_res
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[k] <= '0;
            end else if (res_we && wr_sel == SW'(k)) begin
                res_q[k] <= transformed;
            end
        end
    end

    // R4: index holds between strobes
    assert_index_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !index_we |=> $stable(index_q));

    // R2: bank bits hold between strobes
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable({a16_q, a15_q, mir_q}));
endmodule

// File: rtl/cart_prot_mapper.sv
module cart_prot_mapper
    import cart_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HI_W-1:0]   cpu_addr_hi,
    input  logic [SEL_W-1:0]  cpu_addr_lo,
    input  logic [DATA_W-1:0] cpu_din,
    output logic [DATA_W-1:0] cpu_dout,
    output logic              cpu_doe,
    input  logic              cpu_rw,
    input  logic              m2,
    input  logic              rom_window_n,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    output logic              nt_a10,
    output logic              bank_a16,
    output logic              bank_a15,
    input  logic              or_a,
    input  logic              or_b,
    output logic              or_y
);
    logic bank_we, index_we, res_we;
    logic [SEL_W-1:0]  wr_sel;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] index_q, and_mask, xor_mask;
    logic mir_q;
    logic [NUM_RES-1:0][DATA_W-1:0] res_q;

    cart_prot_bus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .m2       (m2),
        .rw       (cpu_rw),
        .win_n    (rom_window_n),
        .addr_hi  (cpu_addr_hi),
        .addr_lo  (cpu_addr_lo),
        .din      (cpu_din),
        .bank_we  (bank_we),
        .index_we (index_we),
        .res_we   (res_we),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data)
    );

    cart_prot_mask_gen u_mask (
        .idx      (index_q),
        .and_mask (and_mask),
        .xor_mask (xor_mask)
    );

    cart_prot_regs #(.N_RES(NUM_RES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_we  (bank_we),
        .index_we (index_we),
        .res_we   (res_we),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .and_mask (and_mask),
        .xor_mask (xor_mask),
        .index_q  (index_q),
        .a16_q    (bank_a16),
        .a15_q    (bank_a15),
        .mir_q    (mir_q),
        .res_q    (res_q)
    );

    always_comb begin
        cpu_doe  = m2 && cpu_rw && (decode_region(rom_window_n, cpu_addr_hi) == REG_RESULT);
        cpu_dout = cpu_doe ? res_q[cpu_addr_lo] : '0;
        nt_a10   = mir_q ? ppu_a11 : ppu_a10;
        or_y     = or_a | or_b;
    end

    // R6: read enable only during a qualified read phase
    assert_doe_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_doe |-> (m2 && cpu_rw && rom_window_n));
endmodule

// File: tb/cart_prot_mapper_bench.sv
`timescale 1ns/1ps
module cart_prot_mapper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cpu_addr_hi = '0;
    logic [1:0] cpu_addr_lo = '0;
    logic [7:0] cpu_din = '0;
    logic [7:0] cpu_dout;
    logic       cpu_doe;
    logic       cpu_rw = 1'b1;
    logic       m2 = 1'b0;
    logic       rom_window_n = 1'b1;
    logic       ppu_a10 = 1'b0, ppu_a11 = 1'b0;
    logic       nt_a10, bank_a16, bank_a15;
    logic       or_a = 1'b0, or_b = 1'b0;
    logic       or_y;

    int errors = 0;
    int checks = 0;
    logic [7:0] cur_index = 8'h00;
    logic [7:0] model_res [4];

    always #2 clk = ~clk;

    cart_prot_mapper u_cart_prot_mapper (.*);

    function automatic logic [7:0] exp_xor(input logic [7:0] i);
        logic [7:0] m;
        m = 8'h00;
        m[0] = (i[7] & ~i[3]) | (~i[7] & ~i[6]);
        m[3] = (i[4] & ~i[3]) | (~i[6] & ~i[4]);
        m[4] = (~i[6] & ~i[0]) | (~i[3] & i[0]);
        m[6] = (~i[6] & ~i[1]) | (~i[3] & i[1]);
        return m;
    endfunction

    function automatic logic [7:0] exp_and(input logic [7:0] i);
        logic [7:0] m;
        logic a, b;
        a = (i[6] == i[5]);
        b = (i[3] == i[2]);
        m = 8'hFF;
        m[0] = (~i[7] & ~i[6] & ~i[5]) | (~i[7] & i[6] & i[5]) | (i[7] & b);
        m[3] = (a & ~i[4] & ~(i[6] ^ i[5])) | (i[4] & b);
        m[4] = (a & ~i[0]) | (b & i[0]);
        m[6] = (a & ~i[1]) | (b & i[1]);
        return m;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] hi, input logic [1:0] lo,
                             input logic [7:0] d, input logic win_n);
        @(negedge clk);
        cpu_addr_hi = hi; cpu_addr_lo = lo; cpu_din = d;
        cpu_rw = 1'b0; rom_window_n = win_n; m2 = 1'b1;
        repeat (3) @(negedge clk);
        m2 = 1'b0;
        repeat (3) @(negedge clk);
        cpu_rw = 1'b1;
    endtask

    task automatic bus_read(input logic [3:0] hi, input logic [1:0] lo, input logic win_n,
                            output logic [7:0] d, output logic oe);
        @(negedge clk);
        cpu_addr_hi = hi; cpu_addr_lo = lo; cpu_rw = 1'b1; rom_window_n = win_n; m2 = 1'b1;
        repeat (2) @(negedge clk);
        d = cpu_dout; oe = cpu_doe;
        m2 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic res_write(input logic [1:0] sel, input logic [7:0] d);
        bus_write(4'b1011, sel, d, 1'b1);
        model_res[sel] = (d & exp_and(cur_index)) ^ exp_xor(cur_index);
    endtask

    task automatic check_results(input string req);
        logic [7:0] d;
        logic oe;
        for (int k = 0; k < 4; k++) begin
            bus_read(4'b1011, 2'(k), 1'b1, d, oe);
            check(req, d, model_res[k]);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) model_res[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 a16", {7'b0, bank_a16}, 8'h00);
        check("R1 a15", {7'b0, bank_a15}, 8'h00);
        ppu_a10 = 1'b1; ppu_a11 = 1'b0; #1;
        check("R1 nt follows a10", {7'b0, nt_a10}, 8'h01);
        check("R1 idle doe", {7'b0, cpu_doe}, 8'h00);
        check_results("R1 results");
        bus_write(4'b1011, 2'd0, 8'h00, 1'b1);
        model_res[0] = exp_xor(8'h00);
        check_results("R1 index zero");

        // R11 OR gate
        for (int k = 0; k < 4; k++) begin
            or_a = k[0]; or_b = k[1]; #1;
            check("R11 or", {7'b0, or_y}, {7'b0, k[0] | k[1]});
        end

        // R2 bank bits with random A1/A0
        bus_write(4'b1001, 2'($urandom), 8'h11, 1'b1);
        check("R2 a16", {7'b0, bank_a16}, 8'h01);
        check("R2 a15", {7'b0, bank_a15}, 8'h01);
        bus_write(4'b1001, 2'($urandom), 8'hEE, 1'b1);
        check("R2 a16 unused", {7'b0, bank_a16}, 8'h00);
        check("R2 a15 unused", {7'b0, bank_a15}, 8'h00);

        // R3 mirroring (0xEE has bit5 set)
        for (int k = 0; k < 4; k++) begin
            ppu_a10 = k[0]; ppu_a11 = k[1]; #1;
            check("R3 mir1", {7'b0, nt_a10}, {7'b0, k[1]});
        end
        bus_write(4'b1001, 2'($urandom), 8'h01, 1'b1);
        for (int k = 0; k < 4; k++) begin
            ppu_a10 = k[0]; ppu_a11 = k[1]; #1;
            check("R3 mir0", {7'b0, nt_a10}, {7'b0, k[0]});
        end

        // R9 commit only after M2 falls
        @(negedge clk);
        cpu_addr_hi = 4'b1001; cpu_addr_lo = 2'd2; cpu_din = 8'h10;
        cpu_rw = 1'b0; rom_window_n = 1'b1; m2 = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 hold while m2 high", {6'b0, bank_a16, bank_a15}, 8'h02);
        m2 = 1'b0;
        repeat (3) @(negedge clk);
        cpu_rw = 1'b1;
        check("R9 after fall", {6'b0, bank_a16, bank_a15}, 8'h01);

        // R7 R8 R4 R5: all 256 indices, masks observed through writes of 0x00 and 0xFF
        for (int i = 0; i < 256; i++) begin
            logic [1:0] s;
            s = 2'($urandom);
            bus_write(4'b1010, 2'($urandom), 8'(i), 1'b1);
            cur_index = 8'(i);
            res_write(s, 8'h00);
            bus_read(4'b1011, s, 1'b1, d, oe);
            check("R7 xor mask", d, exp_xor(8'(i)));
            res_write(s, 8'hFF);
            bus_read(4'b1011, s, 1'b1, d, oe);
            check("R8 and mask", d, exp_and(8'(i)) ^ exp_xor(8'(i)));
        end
        check("R7 index9", exp_xor(8'd9), 8'h49);
        check("R8 index0", exp_and(8'd0), 8'hFF);

        // R5 independent result registers, random data
        bus_write(4'b1010, 2'd3, 8'h9C, 1'b1);
        cur_index = 8'h9C;
        for (int k = 0; k < 4; k++) res_write(2'(k), 8'($urandom));
        check_results("R5 per-register");
        for (int n = 0; n < 40; n++) begin
            if ($urandom % 3 == 0) begin
                cur_index = 8'($urandom);
                bus_write(4'b1010, 2'($urandom), cur_index, 1'b1);
            end
            res_write(2'($urandom), 8'($urandom));
        end
        check_results("R5 random");

        // R6 read qualification
        bus_read(4'b1011, 2'd1, 1'b1, d, oe);
        check("R6 doe result", {7'b0, oe}, 8'h01);
        bus_read(4'b1001, 2'd1, 1'b1, d, oe);
        check("R6 doe bank range", {7'b0, oe}, 8'h00);
        bus_read(4'b1011, 2'd1, 1'b0, d, oe);
        check("R6 doe window low", {7'b0, oe}, 8'h00);

        // R10 ignored accesses
        for (int k = 12; k < 16; k++) begin
            bus_write(4'(k), 2'($urandom), 8'($urandom), 1'b1);
        end
        bus_write(4'b1001, 2'd0, 8'h31, 1'b0);
        bus_write(4'b1011, 2'd0, 8'h5A, 1'b0);
        bus_write(4'b1010, 2'd0, 8'h77, 1'b0);
        bus_read(4'b1001, 2'd0, 1'b1, d, oe);
        check("R10 bank untouched", {6'b0, bank_a16, bank_a15}, 8'h01);
        check_results("R10 results untouched");
        res_write(2'd2, 8'h00);
        bus_read(4'b1011, 2'd2, 1'b1, d, oe);
        check("R10 index untouched", d, exp_xor(cur_index));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule